// File: doc/BRIEF.md
# Power-Up Default Register Loader

After power-up, and again each time the board reset is released, this block programs three serial slave devices with a fixed set of register values. There is one timing-generator slave and there are two analog front-end slaves. The values come from a constant table that is a parameter of the block. The loader steps through the table one entry at a time. For each entry it sends one write frame on a three-wire port: a serial clock, a serial data line, and one active-low load line per slave.

Every frame has the same layout. It opens with a three-bit device code, sent most significant bit first, followed by a write flag that is always 0. A four-bit address field comes next, sent least significant bit first. For the timing generator this field is a full four-bit address. For a front end it is a three-bit address followed by a test bit that is always 0. The data bits come last, least significant first, and the table entry sets how many there are.

The block drives the serial clock itself from a divided system clock. Data changes only when the serial clock falls. While loading runs, the block does not pass any external serial traffic to the slaves. Once every entry has been written, it raises a done flag and from then on forwards the external serial port to the slaves.

Top module: `reg_default_loader`

## Requirements
- R1: While `rst_n` is low, or while `por_done` has not yet been seen high, the outputs sit at idle: `sclk`=1, `sdata`=0, every bit of `load_n`=1, `done`=0. Asserting `rst_n` low forces idle at once, without waiting for a clock edge.
- R2: `por_done` passes through a two-stage synchroniser. The first frame reaches the outputs on the 4th rising clock edge after `por_done` is first sampled high. If `por_done` is sampled low, the outputs return to idle and `done` clears on the 4th edge after that. The next rise of `por_done` restarts loading from table entry 0.
- R3: Frame bits 0 to 2 carry the device code, most significant bit first. Bit 3 is the write flag and is always 0.
- R4: Frame bits 4 to 7 carry the address, least significant bit first. For code 3'b011 (timing generator) all four address bits are sent. For codes 3'b001 and 3'b010 (front ends) address bits 0 to 2 are sent, and bit 7 is a test bit sent as 0, whatever the table's address bit 3 holds.
- R5: From frame bit 8 onward, the data bits are sent least significant first. The count equals the entry's length field plus 1 (1 to 16 bits). Data bits above that count are never sent.
- R6: Each frame bit lasts 2*HALF clocks. `sclk` is low for the first HALF clocks and high for the last HALF clocks. Inside a frame, `sdata` changes only in the cycle where `sclk` falls.
- R7: During a frame exactly one load line is low. Code 3'b011 selects `load_n[0]`, code 3'b001 selects `load_n[1]`, and code 3'b010 selects `load_n[2]`. After each frame, every load line stays high for exactly 4*HALF clocks (two serial clock periods), with `sclk`=1 and `sdata`=0.
- R8: Entries are sent in table index order, starting at index 0. `done` rises in the cycle after the gap that follows the last frame. It then stays high until `rst_n` or `por_done` goes low.
- R9: Until `done` is high, the external serial inputs have no effect on any output. While `done` is high, `sclk`, `sdata` and `load_n` show `ext_sclk`, `ext_sdata` and `ext_load_n` with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| por_done | input | 1 | High once the long power-on/board-reset delay has expired; asynchronous |
| ext_sclk | input | 1 | External serial clock, forwarded after loading |
| ext_sdata | input | 1 | External serial data, forwarded after loading |
| ext_load_n | input | 3 | External per-slave load lines, forwarded after loading |
| sclk | output | 1 | Serial clock to the slaves |
| sdata | output | 1 | Serial data to the slaves |
| load_n | output | 3 | Active-low load line per slave: [0] timing generator, [1] front end A, [2] front end B |
| done | output | 1 | All default entries have been written |

## Verification
The embedded assertions run on every cycle. They check that at most one load line is low while loading, that data moves only on a falling serial clock inside a frame, that the lines sit at idle between frames, that every inter-frame gap runs its full length, that the table index stays in range, and that `done` holds once reached. Only the bench scenarios can show the rest: the exact bit content of each frame (code order, masked test bit, truncated data), the four-cycle start and abort latency, a restart from entry 0 after a mid-frame abort or an asynchronous reset, and the switch from ignoring the external port to forwarding it.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

  localparam int CODE_W    = 3;
  localparam int ADDR_W    = 4;
  localparam int LEN_W     = 4;
  localparam int DATA_W    = 16;
  localparam int NDEV      = 3;
  localparam int HDR_BITS  = CODE_W + 1 + ADDR_W;
  localparam int FRAME_MAX = HDR_BITS + DATA_W;
  localparam int BIT_W     = $clog2(FRAME_MAX);

  localparam logic [CODE_W-1:0] CODE_AFE_A = 3'b001;
  localparam logic [CODE_W-1:0] CODE_AFE_B = 3'b010;
  localparam logic [CODE_W-1:0] CODE_TMG   = 3'b011;

  // One default write: target code, register address, data length - 1, value.
  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len_m1;
    logic [DATA_W-1:0] data;
  } entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP, ST_DONE} state_t;

  // Device code owning each load lane.
  function automatic logic [CODE_W-1:0] lane_code(int lane);
    case (lane)
      0:       return CODE_TMG;
      1:       return CODE_AFE_A;
      default: return CODE_AFE_B;
    endcase
  endfunction

endpackage

// File: rtl/rdl_sync.sv
module rdl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= '0;
    end else begin
      ff_q <= ff_d;
    end
  end

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/rdl_baud.sv
module rdl_baud #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int PH_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF - 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  assign tick = en && (ph_q == PH_LAST);

  always_comb begin
    if (!en || tick) begin
      ph_d = '0;
    end else begin
      ph_d = ph_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  AST_PHASE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ph_q == '0)); // R6

endmodule

// File: rtl/rdl_framer.sv
module rdl_framer
  import rdl_pkg::*;
(
  input  entry_t             ent,
  input  logic [BIT_W-1:0]   bit_idx,
  output logic               tx_bit,
  output logic [NDEV-1:0]    lane_load_n,
  output logic               frame_last
);

  logic                  is_tmg;
  logic [ADDR_W-1:0]     addr_tx;
  logic [FRAME_MAX-1:0]  fvec;

  assign is_tmg = (ent.code == CODE_TMG);

  // Front ends take three address bits; the top slot carries the test bit (0).
  assign addr_tx = is_tmg ? ent.addr : {1'b0, ent.addr[ADDR_W-2:0]};

  // Transmit order from bit 0 upward: code MSB first, write flag, address, data.
  assign fvec = {ent.data, addr_tx, 1'b0, ent.code[0], ent.code[1], ent.code[2]};

  assign tx_bit     = fvec[bit_idx];
  assign frame_last = (bit_idx == (BIT_W'(HDR_BITS) + BIT_W'(ent.len_m1)));

  for (genvar g = 0; g < NDEV; g++) begin : g_lane
    localparam logic [CODE_W-1:0] LANE_CODE = lane_code(g);
    assign lane_load_n[g] = (ent.code != LANE_CODE);
  end

endmodule

// File: rtl/rdl_seq.sv
module rdl_seq
  import rdl_pkg::*;
#(
  parameter int N_ENT   = 6,
  parameter int GAP_CYC = 8,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              frame_last,
  output state_t            state,
  output logic [IDX_W-1:0]  idx,
  output logic [BIT_W-1:0]  bit_idx,
  output logic              hi
);

  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_ENT - 1);

  state_t            state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              hi_q, hi_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              bit_en;
  logic              gap_en;

  // Clock enables: bit position moves only on a baud tick, gap counter only in the gap.
  assign bit_en = (state_q == ST_FRAME) && tick;
  assign gap_en = (state_q == ST_GAP);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    bit_d   = bit_q;
    hi_d    = hi_q;
    gap_d   = gap_q;
    if (!run) begin
      state_d = ST_IDLE;
      idx_d   = '0;
      bit_d   = '0;
      hi_d    = 1'b0;
      gap_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_FRAME;
        end
        ST_FRAME: begin
          if (bit_en) begin
            if (!hi_q) begin
              hi_d = 1'b1;
            end else begin
              hi_d = 1'b0;
              if (frame_last) begin
                bit_d   = '0;
                gap_d   = '0;
                state_d = ST_GAP;
              end else begin
                bit_d = bit_q + BIT_W'(1);
              end
            end
          end
        end
        ST_GAP: begin
          if (gap_en) begin
            if (gap_q == GAP_LAST) begin
              gap_d = '0;
              if (idx_q == IDX_LAST) begin
                state_d = ST_DONE;
              end else begin
                idx_d   = idx_q + IDX_W'(1);
                state_d = ST_FRAME;
              end
            end else begin
              gap_d = gap_q + GAP_W'(1);
            end
          end
        end
        ST_DONE: begin
          state_d = ST_DONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      bit_q   <= '0;
      hi_q    <= 1'b0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      bit_q   <= bit_d;
      hi_q    <= hi_d;
      gap_q   <= gap_d;
    end
  end

  assign state   = state_q;
  assign idx     = idx_q;
  assign bit_idx = bit_q;
  assign hi      = hi_q;

  AST_GAP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FRAME) && ($past(state_q) == ST_GAP) |-> ($past(gap_q) == GAP_LAST)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) && run |=> (state_q == ST_DONE)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_LAST); // R8
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FRAME) |-> (bit_q < BIT_W'(FRAME_MAX))); // R5

endmodule

// File: rtl/reg_default_loader.sv
module reg_default_loader
  import rdl_pkg::*;
#(
  parameter int HALF    = 2,
  parameter int GAP_PER = 2,
  parameter int N_ENT   = 6,
  parameter entry_t [N_ENT-1:0] TABLE = {
    {3'b010, 4'd5,  4'd5,  16'h0015},
    {3'b010, 4'd13, 4'd11, 16'hF0F3},
    {3'b001, 4'd7,  4'd0,  16'h0001},
    {3'b001, 4'd3,  4'd9,  16'h02C5},
    {3'b011, 4'd10, 4'd15, 16'hBEEF},
    {3'b011, 4'd0,  4'd7,  16'h005A}
  }
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            por_done,
  input  logic            ext_sclk,
  input  logic            ext_sdata,
  input  logic [2:0]      ext_load_n,
  output logic            sclk,
  output logic            sdata,
  output logic [2:0]      load_n,
  output logic            done
);

  localparam int GAP_CYC = 2 * HALF * GAP_PER;
  localparam int IDX_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic              run;
  logic              tick;
  state_t            state;
  logic [IDX_W-1:0]  idx;
  logic [BIT_W-1:0]  bit_idx;
  logic              hi;
  entry_t            cur;
  logic              fr_bit;
  logic [NDEV-1:0]   fr_load_n;
  logic              frame_last;

  logic              sclk_d;
  logic              sdata_d;
  logic [NDEV-1:0]   load_d;
  logic              done_d;

  rdl_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (por_done),
    .q     (run)
  );

  rdl_baud #(.HALF(HALF)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (state == ST_FRAME),
    .tick  (tick)
  );

  rdl_seq #(
    .N_ENT   (N_ENT),
    .GAP_CYC (GAP_CYC),
    .IDX_W   (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (tick),
    .frame_last (frame_last),
    .state      (state),
    .idx        (idx),
    .bit_idx    (bit_idx),
    .hi         (hi)
  );

  assign cur = TABLE[idx];

  rdl_framer u_framer (
    .ent         (cur),
    .bit_idx     (bit_idx),
    .tx_bit      (fr_bit),
    .lane_load_n (fr_load_n),
    .frame_last  (frame_last)
  );

  // Output select: own frame, idle lines, or forwarded external port.
  always_comb begin
    sclk_d  = 1'b1;
    sdata_d = 1'b0;
    load_d  = '1;
    done_d  = 1'b0;
    unique case (state)
      ST_FRAME: begin
        sclk_d  = hi;
        sdata_d = fr_bit;
        load_d  = fr_load_n;
      end
      ST_DONE: begin
        sclk_d  = ext_sclk;
        sdata_d = ext_sdata;
        load_d  = ext_load_n;
        done_d  = 1'b1;
      end
      default: begin
        sclk_d  = 1'b1;
        sdata_d = 1'b0;
        load_d  = '1;
        done_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk   <= 1'b1;
      sdata  <= 1'b0;
      load_n <= '1;
      done   <= 1'b0;
    end else begin
      sclk   <= sclk_d;
      sdata  <= sdata_d;
      load_n <= load_d;
      done   <= done_d;
    end
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $onehot0(~load_n)); // R7
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !(&load_n) && !$past(&load_n) && $changed(sdata) |-> $fell(sclk)); // R6
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !done && (&load_n) |-> sclk && !sdata); // R1

endmodule

// File: tb/tb_reg_default_loader.sv
module tb_reg_default_loader;

  localparam int HALF    = 2;
  localparam int GAP_CYC = 4 * HALF;
  localparam int NE      = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_done = 1'b0;
  logic       ext_sclk = 1'b0;
  logic       ext_sdata = 1'b0;
  logic [2:0] ext_load_n = 3'b111;
  logic       sclk;
  logic       sdata;
  logic [2:0] load_n;
  logic       done;

  reg_default_loader dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_done   (por_done),
    .ext_sclk   (ext_sclk),
    .ext_sdata  (ext_sdata),
    .ext_load_n (ext_load_n),
    .sclk       (sclk),
    .sdata      (sdata),
    .load_n     (load_n),
    .done       (done)
  );

  always #2 clk = ~clk;

  // Expected default table, entry 0 first.
  logic [2:0]  t_code [NE] = '{3'b011, 3'b011, 3'b001, 3'b001, 3'b010, 3'b010};
  logic [3:0]  t_addr [NE] = '{4'd0, 4'd10, 4'd3, 4'd7, 4'd13, 4'd5};
  int          t_len  [NE] = '{8, 16, 10, 1, 12, 6};
  logic [15:0] t_data [NE] = '{16'h005A, 16'hBEEF, 16'h02C5, 16'h0001, 16'hF0F3, 16'h0015};

  int vectors = 0;
  int misses  = 0;
  bit chk_on  = 1'b0;

  logic       e_sclk = 1'b1;
  logic       e_sdata = 1'b0;
  logic [2:0] e_load = 3'b111;
  logic       e_done = 1'b0;
  string      tg_sc = "R1";
  string      tg_sd = "R1";
  string      tg_ld = "R1";
  string      tg_dn = "R1";

  logic [2:0]  por_hist = 3'b000;
  logic        h_now;
  int unsigned tpos = 0;

  function automatic logic [2:0] lane_of(logic [2:0] c);
    if (c == 3'b011) return 3'b110;
    if (c == 3'b001) return 3'b101;
    return 3'b011;
  endfunction

  function automatic logic fbit(int e, int b);
    logic q[$];
    for (int i = 2; i >= 0; i--) q.push_back(t_code[e][i]);
    q.push_back(1'b0);
    for (int i = 0; i < 4; i++)
      q.push_back((i == 3 && t_code[e] != 3'b011) ? 1'b0 : t_addr[e][i]);
    for (int i = 0; i < t_len[e]; i++) q.push_back(t_data[e][i]);
    return q[b];
  endfunction

  task automatic set_idle(string t);
    e_sclk = 1'b1; e_sdata = 1'b0; e_load = 3'b111; e_done = 1'b0;
    tg_sc = t; tg_sd = t; tg_ld = t; tg_dn = t;
  endtask

  task automatic expect_at(int unsigned t);
    int rem;
    rem = int'(t);
    for (int e = 0; e < NE; e++) begin
      int nb;
      int fl;
      int b;
      nb = 8 + t_len[e];
      fl = nb * 2 * HALF;
      if (rem < fl) begin
        b       = rem / (2 * HALF);
        e_sclk  = ((rem % (2 * HALF)) >= HALF);
        e_sdata = fbit(e, b);
        e_load  = lane_of(t_code[e]);
        e_done  = 1'b0;
        tg_sc   = "R6";
        tg_sd   = (b < 4) ? "R3" : ((b < 8) ? "R4" : "R5");
        tg_ld   = "R7";
        tg_dn   = "R8";
        return;
      end
      rem = rem - fl;
      if (rem < GAP_CYC) begin
        set_idle("R7");
        tg_dn = "R8";
        return;
      end
      rem = rem - GAP_CYC;
    end
    e_sclk = ext_sclk; e_sdata = ext_sdata; e_load = ext_load_n; e_done = 1'b1;
    tg_sc = "R9"; tg_sd = "R9"; tg_ld = "R9"; tg_dn = "R8";
  endtask

  // Reference model: output after edge n follows por_done sampled at edge n-3.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_hist = 3'b000;
      tpos = 0;
      set_idle("R1");
    end else begin
      h_now = por_hist[2];
      por_hist = {por_hist[1:0], por_done};
      if (!h_now) begin
        tpos = 0;
        set_idle("R1");
      end else begin
        expect_at(tpos);
        tpos = tpos + 1;
      end
    end
  end

  // External port traffic, changing every cycle.
  logic [7:0] lfsr = 8'hA7;
  always @(negedge clk) begin
    lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ext_sclk   <= lfsr[0];
    ext_sdata  <= lfsr[3];
    ext_load_n <= lfsr[7:5];
  end

  task automatic cmp(input logic [2:0] act, input logic [2:0] exp, input string tag, input string nm);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      cmp({2'b0, sclk},  {2'b0, e_sclk},  tg_sc, "sclk");
      cmp({2'b0, sdata}, {2'b0, e_sdata}, tg_sd, "sdata");
      cmp(load_n,        e_load,          tg_ld, "load_n");
      cmp({2'b0, done},  {2'b0, e_done},  tg_dn, "done");
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    cmp({2'b0, done}, 3'b001, "R8", "done reached");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #400000;
    misses++;
    $display("FAIL R8 watchdog: done actual %0b expected 1", done);
    finish_run();
  end

  initial begin
    @(negedge clk);
    chk_on = 1'b1;
    repeat (4) @(negedge clk);
    cmp({sclk, sdata, done}, 3'b100, "R1", "reset idle lines");
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    cmp(load_n, 3'b111, "R1", "idle before por_done");

    // First load: start latency.
    por_done = 1'b1;
    repeat (3) @(negedge clk);
    cmp(load_n, 3'b111, "R2", "load_n 3 edges after por_done");
    @(negedge clk);
    cmp(load_n, 3'b110, "R2", "load_n 4 edges after por_done");
    wait_done();
    repeat (20) @(negedge clk);
    cmp({2'b0, done}, 3'b001, "R8", "done held");

    // Board reset pressed: done clears after the same latency.
    por_done = 1'b0;
    repeat (3) @(negedge clk);
    cmp({2'b0, done}, 3'b001, "R2", "done 3 edges after drop");
    @(negedge clk);
    cmp({2'b0, done}, 3'b000, "R2", "done 4 edges after drop");
    repeat (6) @(negedge clk);

    // Abort mid-frame, then reload from entry 0.
    por_done = 1'b1;
    repeat (101) @(negedge clk);
    por_done = 1'b0;
    repeat (12) @(negedge clk);
    cmp(load_n, 3'b111, "R2", "idle after abort");
    por_done = 1'b1;
    wait_done();

    // Asynchronous reset in the middle of a reload.
    por_done = 1'b0;
    repeat (8) @(negedge clk);
    por_done = 1'b1;
    repeat (150) @(negedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    cmp({sclk, sdata, done}, 3'b100, "R1", "async reset lines");
    cmp(load_n, 3'b111, "R1", "async reset load");
    @(negedge clk);
    rst_n = 1'b1;
    wait_done();
    repeat (30) @(negedge clk);
    finish_run();
  end

endmodule